// File: doc/BRIEF.md
# Phased SPI Command Master

This block is a memory-mapped SPI master for serial-flash style exchanges. Software fills a command register and a byte buffer, then writes one bit-count register that sizes three consecutive phases: a command phase, an extra transmit phase and a receive phase. Setting the start bit runs the whole exchange. The block shifts out the command, then the buffered transmit bytes, then samples incoming bytes back into the same buffer. A busy flag stays high until the last bit has been clocked.

The chip-select pin follows one software-controlled register bit, so software frames a transaction by asserting it before start and releasing it after busy clears. The serial clock comes from a fixed divider field in a configuration register. The bus is a plain 32-bit register read/write port. Read data appears one cycle after the read strobe.

Register map (byte offsets): control/status 0x00 (bit 8 write = start, bit 16 read = busy), command 0x04, buffer words 0x08 upward, configuration 0x28 (divider in bits [27:16]), bit counts 0x2C (command bits [29:24], receive bits [20:12], extra-transmit bits [11:0]), chip-select enable 0x38 bit 0.

Top module: `spi_cmd_master`

## Requirements
- R1: After reset the busy bit (offset 0x00 bit 16) reads 0, `spi_cs_n` is 1, `spi_sck` is 0, every buffer word reads 0 and the configuration register reads 0xE00D0004 (divider 13).
- R2: Writing 1 to bit 8 of offset 0x00 sets busy. Busy stays 1 until the final bit of the last non-empty phase has been clocked, then returns to 0.
- R3: The command phase sends `min(count[29:24], 32)` bits of the command register MSB first, starting at bit (count-1), so a short command is right-justified.
- R4: Extra transmit bits follow the command. Byte k comes from word k/4 of the buffer, bits [8*(k%4)+7 : 8*(k%4)], lowest byte first, each byte MSB first. Up to 32 bytes (256 bits) are sent.
- R5: Receive bits follow the transmit phases, with MOSI held 0. Received byte k, first bit as its MSB, is stored at bits [8*(k%4)+7 : 8*(k%4)] of buffer word k/4. Up to 32 bytes are received.
- R6: SCK idles low (SPI mode 0). MOSI changes only while SCK falls or is low, and the MISO sample is taken as SCK rises. SCK runs at clk/(2*(div+1)), where div is configuration bits [27:16].
- R7: `spi_cs_n` is 0 exactly while bit 0 of offset 0x38 is 1.
- R8: While busy, writes to the command, buffer, configuration and count registers are ignored, and a further start request launches nothing.
- R9: A phase whose bit count is zero is skipped. With all counts zero, busy reads 0 again two cycles after the start write, and SCK never toggles.
- R10: SCK stays low whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_re` |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The assertions assume that the bus never writes and starts in the same cycle through two paths, which the single-port bus ensures. They also assume that MISO is only read at the rising SCK edge, so its value elsewhere is free. The bench drives its MISO model from the count of rising SCK edges it has seen, so a new bit is presented only after the design has sampled the previous one. It programs only aligned addresses inside the map and waits for busy to clear before it reconfigures anything, except in the scenario that deliberately writes during busy.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int A_CTRL = 'h00;
  localparam int A_CMD  = 'h04;
  localparam int A_BUF0 = 'h08;
  localparam int A_CFG  = 'h28;
  localparam int A_CNT  = 'h2C;
  localparam int A_CS   = 'h38;

  localparam logic [31:0] CFG_RESET = 32'hE00D_0004;
  localparam int MAX_CMD_BITS = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_FIN} eng_state_t;
endpackage

// File: rtl/spi_cmd_clkgen.sv
module spi_cmd_clkgen #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int BUF_WORDS = 8,
  parameter int ADDR_W    = 8,
  parameter int DIV_W     = 12,
  parameter int BIT_W     = 10,
  parameter int BYTE_W    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  input  logic              busy,
  input  logic [BYTE_W-1:0] eng_rd_idx,
  output logic [7:0]        eng_rd_byte,
  input  logic              eng_we,
  input  logic [BYTE_W-1:0] eng_wr_idx,
  input  logic [7:0]        eng_wr_byte,
  output logic [31:0]       cmd_word,
  output logic [BIT_W-1:0]  cmd_bits,
  output logic [BIT_W-1:0]  tx_bits,
  output logic [BIT_W-1:0]  rx_bits,
  output logic [DIV_W-1:0]  div,
  output logic              cs_en,
  output logic              start_req
);
  localparam int WIDX_W   = $clog2(BUF_WORDS);
  localparam int BUF_END  = A_BUF0 + 4 * BUF_WORDS;
  localparam int MAX_DATA = 32 * BUF_WORDS;

  logic [31:0] buf_mem [BUF_WORDS];
  logic [31:0] cmd_q, cfg_q, cnt_q;
  logic        cs_q;

  logic              buf_hit;
  logic [ADDR_W-1:0] addr_off;
  logic [WIDX_W-1:0] buf_widx;
  logic              wr_ok;

  assign addr_off = bus_addr - ADDR_W'(A_BUF0);
  assign buf_widx = WIDX_W'(addr_off >> 2);
  assign buf_hit  = (bus_addr >= ADDR_W'(A_BUF0)) && (bus_addr < ADDR_W'(BUF_END))
                    && (bus_addr[1:0] == 2'b00);
  assign wr_ok    = bus_we && !busy;

  assign start_req = wr_ok && (bus_addr == ADDR_W'(A_CTRL)) && bus_wdata[8];

  always_comb begin
    cmd_bits = (cnt_q[29:24] > 6'(MAX_CMD_BITS)) ? BIT_W'(MAX_CMD_BITS)
                                                 : BIT_W'(cnt_q[29:24]);
    tx_bits  = (cnt_q[11:0] > 12'(MAX_DATA)) ? BIT_W'(MAX_DATA) : BIT_W'(cnt_q[11:0]);
    rx_bits  = (cnt_q[20:12] > 9'(MAX_DATA)) ? BIT_W'(MAX_DATA) : BIT_W'(cnt_q[20:12]);
  end

  assign cmd_word = cmd_q;
  assign div      = cfg_q[16 +: DIV_W];
  assign cs_en    = cs_q;

  assign eng_rd_byte = buf_mem[WIDX_W'(eng_rd_idx >> 2)][8*eng_rd_idx[1:0] +: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      cfg_q <= CFG_RESET;
      cnt_q <= '0;
      cs_q  <= 1'b0;
      for (int w = 0; w < BUF_WORDS; w++) buf_mem[w] <= '0;
    end else begin
      if (bus_we && bus_addr == ADDR_W'(A_CS)) cs_q <= bus_wdata[0];
      if (wr_ok) begin
        if (bus_addr == ADDR_W'(A_CMD)) cmd_q <= bus_wdata;
        if (bus_addr == ADDR_W'(A_CFG)) cfg_q <= bus_wdata;
        if (bus_addr == ADDR_W'(A_CNT)) cnt_q <= bus_wdata;
        if (buf_hit) buf_mem[buf_widx] <= bus_wdata;
      end
      if (eng_we)
        buf_mem[WIDX_W'(eng_wr_idx >> 2)][8*eng_wr_idx[1:0] +: 8] <= eng_wr_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_re) begin
      bus_rdata <= '0;
      if (bus_addr == ADDR_W'(A_CTRL)) bus_rdata <= {15'b0, busy, 16'b0};
      if (bus_addr == ADDR_W'(A_CMD))  bus_rdata <= cmd_q;
      if (bus_addr == ADDR_W'(A_CFG))  bus_rdata <= cfg_q;
      if (bus_addr == ADDR_W'(A_CNT))  bus_rdata <= cnt_q;
      if (bus_addr == ADDR_W'(A_CS))   bus_rdata <= {31'b0, cs_q};
      if (buf_hit)                     bus_rdata <= buf_mem[buf_widx];
    end
  end

  // R8: a busy engine freezes the command and count registers
  p_hold_cmd_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cmd_q));
  p_hold_cnt_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cnt_q));
  // R3: the engine never sees more than 32 command bits
  p_cmd_clamp_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_bits <= BIT_W'(MAX_CMD_BITS));
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int BIT_W  = 10,
  parameter int BYTE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic [31:0]       cmd_word,
  input  logic [BIT_W-1:0]  cmd_bits,
  input  logic [BIT_W-1:0]  tx_bits,
  input  logic [BIT_W-1:0]  rx_bits,
  input  logic              tick,
  input  logic              miso,
  input  logic [7:0]        tx_byte,
  output logic [BYTE_W-1:0] rd_idx,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_idx,
  output logic [7:0]        wr_byte,
  output logic              run,
  output logic              busy,
  output logic              sck,
  output logic              mosi
);
  eng_state_t       state_q;
  logic [BIT_W-1:0] bit_q;
  logic [7:0]       rx_sh;

  logic [BIT_W-1:0] tx_end, total, sel, j_tx, j_rx, cmd_pos;
  logic             next_mosi, last_bit;

  assign tx_end   = cmd_bits + tx_bits;
  assign total    = tx_end + rx_bits;
  assign sel      = (state_q == ST_IDLE) ? '0 : bit_q + 1'b1;
  assign j_tx     = sel - cmd_bits;
  assign j_rx     = bit_q - tx_end;
  assign cmd_pos  = cmd_bits - 1'b1 - sel;
  assign rd_idx   = BYTE_W'(j_tx >> 3);
  assign last_bit = (bit_q == total - 1'b1);

  always_comb begin
    if (sel < cmd_bits)    next_mosi = cmd_word[5'(cmd_pos)];
    else if (sel < tx_end) next_mosi = tx_byte[~3'(j_tx)];
    else                   next_mosi = 1'b0;
  end

  assign run  = (state_q == ST_SHIFT);
  assign busy = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sck     <= 1'b0;
      mosi    <= 1'b0;
      rx_sh   <= '0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_byte <= '0;
    end else begin
      wr_en <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_req) begin
          bit_q <= '0;
          sck   <= 1'b0;
          rx_sh <= '0;
          if (total == '0) state_q <= ST_FIN;
          else begin
            state_q <= ST_SHIFT;
            mosi    <= next_mosi;
          end
        end
        ST_SHIFT: if (tick) begin
          if (!sck) begin
            sck <= 1'b1;
            if (bit_q >= tx_end) begin
              rx_sh <= {rx_sh[6:0], miso};
              if (3'(j_rx) == 3'd7 || last_bit) begin
                wr_en   <= 1'b1;
                wr_idx  <= BYTE_W'(j_rx >> 3);
                wr_byte <= {rx_sh[6:0], miso};
              end
            end
          end else begin
            sck <= 1'b0;
            if (last_bit) begin
              state_q <= ST_IDLE;
              mosi    <= 1'b0;
            end else begin
              bit_q <= bit_q + 1'b1;
              mosi  <= next_mosi;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10: the serial clock rests low outside a transfer
  p_sck_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sck);
  // R6: data is steady across every rising serial clock edge
  p_mosi_stable_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sck) |-> $stable(mosi));
  // R2: an accepted start always raises busy
  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    start_req |=> busy);
  // R9: the empty-transfer state lasts one cycle
  p_zero_done_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FIN) |=> !busy);
  // R3/R4/R5: the bit counter stays inside the programmed length
  p_bit_bound_r4: assert property (@(posedge clk) disable iff (rst)
    run |-> (bit_q < total));
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master #(
  parameter int BUF_WORDS = 8,
  parameter int ADDR_W    = 8,
  parameter int DIV_W     = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  localparam int BYTE_W = $clog2(BUF_WORDS * 4);
  localparam int BIT_W  = $clog2(32 + 2 * 32 * BUF_WORDS + 1);

  logic              busy, run, tick, cs_en, start_req;
  logic              eng_we;
  logic [BYTE_W-1:0] rd_idx, wr_idx;
  logic [7:0]        rd_byte, wr_byte;
  logic [31:0]       cmd_word;
  logic [BIT_W-1:0]  cmd_bits, tx_bits, rx_bits;
  logic [DIV_W-1:0]  div;

  spi_cmd_regs #(
    .BUF_WORDS(BUF_WORDS), .ADDR_W(ADDR_W), .DIV_W(DIV_W),
    .BIT_W(BIT_W), .BYTE_W(BYTE_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_re(bus_re), .bus_rdata(bus_rdata),
    .busy(busy),
    .eng_rd_idx(rd_idx), .eng_rd_byte(rd_byte),
    .eng_we(eng_we), .eng_wr_idx(wr_idx), .eng_wr_byte(wr_byte),
    .cmd_word(cmd_word), .cmd_bits(cmd_bits), .tx_bits(tx_bits), .rx_bits(rx_bits),
    .div(div), .cs_en(cs_en), .start_req(start_req)
  );

  spi_cmd_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst(rst), .run(run), .div(div), .tick(tick)
  );

  spi_cmd_engine #(.BIT_W(BIT_W), .BYTE_W(BYTE_W)) u_engine (
    .clk(clk), .rst(rst), .start_req(start_req),
    .cmd_word(cmd_word), .cmd_bits(cmd_bits), .tx_bits(tx_bits), .rx_bits(rx_bits),
    .tick(tick), .miso(spi_miso), .tx_byte(rd_byte), .rd_idx(rd_idx),
    .wr_en(eng_we), .wr_idx(wr_idx), .wr_byte(wr_byte),
    .run(run), .busy(busy), .sck(spi_sck), .mosi(spi_mosi)
  );

  assign spi_cs_n = ~cs_en;

  // R7: chip select mirrors the enable bit
  p_cs_follow_r7: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n != cs_en);
endmodule

// File: tb/spi_cmd_master_bench.sv
`timescale 1ns/1ps
module spi_cmd_master_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_mosi, spi_miso, spi_cs_n;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  spi_cmd_master u_spi_cmd_master (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  // serial slave model
  logic     cap [4096];
  int       ncap = 0;
  realtime  t_last = 0, t_prev = 0;
  logic [7:0] rx_bytes [32];
  int       rx_base = 1 << 20;
  int       rx_n = 0;

  always @(posedge spi_sck) begin
    cap[ncap] <= spi_mosi;
    ncap      <= ncap + 1;
    t_prev    <= t_last;
    t_last    <= $realtime;
  end

  assign spi_miso = (ncap >= rx_base && ncap < rx_base + 8 * rx_n)
                    ? rx_bytes[(ncap - rx_base) / 8][7 - ((ncap - rx_base) % 8)] : 1'b0;

  logic exp_bits [4096];
  int   nexp;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 8'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 8'(a); bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd('h00, v);
      if (!v[16]) return;
    end
  endtask

  task automatic push(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      exp_bits[nexp] = v[i];
      nexp++;
    end
  endtask

  task automatic cmp_bits(input int base, input string req);
    int bad = 0;
    for (int i = 0; i < nexp; i++) if (cap[base + i] !== exp_bits[i]) bad++;
    chk(ncap - base == nexp, req, 32'(ncap - base), 32'(nexp));
    chk(bad == 0, req, 32'(bad), 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk(spi_sck == 1'b0, "R1", 32'(spi_sck), 0);
    chk(spi_cs_n == 1'b1, "R1", 32'(spi_cs_n), 1);
    rd('h00, v); chk(v == 0, "R1", v, 0);
    rd('h28, v); chk(v == 32'hE00D_0004, "R1", v, 32'hE00D_0004);
    for (int w = 0; w < 8; w++) begin
      rd('h08 + 4 * w, v); chk(v == 0, "R1", v, 0);
    end
  endtask

  task automatic t_cs();
    wr('h38, 1); @(negedge clk);
    chk(spi_cs_n == 1'b0, "R7", 32'(spi_cs_n), 0);
    wr('h38, 0); @(negedge clk);
    chk(spi_cs_n == 1'b1, "R7", 32'(spi_cs_n), 1);
  endtask

  task automatic t_cmd_only();
    logic [31:0] v;
    int base;
    wr('h28, 32'hE001_0004);        // divider 1: SCK half period 2 clocks
    wr('h04, 32'h0000_A55A);
    wr('h2C, 32'(16) << 24);
    wr('h38, 1);
    base = ncap; nexp = 0; push(32'hA55A, 16);
    wr('h00, 32'h100);
    rd('h00, v); chk(v[16] == 1'b1, "R2", v, 32'h0001_0000);
    wait_idle();
    chk(spi_sck == 1'b0, "R10", 32'(spi_sck), 0);
    wr('h38, 0);
    cmp_bits(base, "R3");
    chk((t_last - t_prev) == 16.0, "R6", 32'(int'(t_last - t_prev)), 16);
  endtask

  task automatic t_full();
    logic [31:0] v;
    int base;
    wr('h04, 32'h0000_0003);
    wr('h08, 32'h4433_2211);
    wr('h0C, 32'h0000_0055);
    wr('h2C, (32'(8) << 24) | (32'(48) << 12) | 32'(40));
    for (int k = 0; k < 6; k++) rx_bytes[k] = 8'hA1 + 8'(k);
    base = ncap; rx_base = base + 48; rx_n = 6;
    nexp = 0; push(3, 8); push(32'h11223344, 32); push(32'h55, 8); push(0, 48);
    wr('h38, 1);
    wr('h00, 32'h100);
    wait_idle();
    wr('h38, 0);
    cmp_bits(base, "R4");
    rd('h08, v); chk(v == 32'hA4A3_A2A1, "R5", v, 32'hA4A3_A2A1);
    rd('h0C, v); chk(v == 32'h0000_A6A5, "R5", v, 32'h0000_A6A5);
    rx_base = 1 << 20; rx_n = 0;
  endtask

  task automatic t_max();
    int base;
    wr('h04, 32'hC0FF_EE11);
    for (int w = 0; w < 8; w++)
      wr('h08 + 4 * w, {8'(4*w + 'h13), 8'(4*w + 'h12), 8'(4*w + 'h11), 8'(4*w + 'h10)});
    wr('h2C, (32'(63) << 24) | 32'(256));   // command count above 32 clamps to 32
    base = ncap; nexp = 0; push(32'hC0FF_EE11, 32);
    for (int k = 0; k < 32; k++) push(32'(k + 'h10), 8);
    wr('h00, 32'h100);
    wait_idle();
    cmp_bits(base, "R3");
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    int base, after;
    wr('h24, 32'h0000_0077);
    wr('h04, 32'h0000_000B);
    wr('h2C, (32'(8) << 24) | (32'(16) << 12));
    rx_bytes[0] = 8'h3C; rx_bytes[1] = 8'hC3;
    base = ncap; rx_base = base + 8; rx_n = 2;
    wr('h00, 32'h100);
    wr('h04, 32'hFF);
    wr('h2C, 0);
    wr('h24, 32'hDEAD);
    wr('h00, 32'h100);
    wait_idle();
    repeat (50) @(negedge clk);
    after = ncap - base;
    chk(after == 24, "R8", 32'(after), 24);
    rd('h04, v); chk(v == 32'h0B, "R8", v, 32'h0B);
    rd('h2C, v); chk(v == ((32'(8) << 24) | (32'(16) << 12)), "R8", v,
                     (32'(8) << 24) | (32'(16) << 12));
    rd('h24, v); chk(v == 32'h77, "R8", v, 32'h77);
    rd('h08, v); chk(v[15:0] == 16'hC33C, "R5", v, 32'h0000_C33C);
    rx_base = 1 << 20; rx_n = 0;
  endtask

  task automatic t_zero();
    logic [31:0] v;
    int base;
    wr('h2C, 0);
    base = ncap;
    wr('h00, 32'h100);
    rd('h00, v); chk(v[16] == 1'b0, "R9", v, 0);
    chk(ncap == base, "R9", 32'(ncap - base), 0);
    // command skipped, transmit only
    wr('h08, 32'h0000_0081);
    wr('h2C, 32'(8));
    base = ncap; nexp = 0; push(32'h81, 8);
    wr('h00, 32'h100);
    wait_idle();
    cmp_bits(base, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_cs();
    t_cmd_only();
    t_full();
    t_max();
    t_busy_ignore();
    t_zero();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule